// File: doc/BRIEF.md
# Dual Serial-Audio Sample Interleaver

This block merges two mono serial audio streams into one. The two input data lines share one bit clock and one word-select line. Each word-select half-period carries one 16-bit sample on each line. The block collects a complete sample from each line. It then sends the two samples one after the other on a single output data line, at twice the input bit rate, so a receiver gets both channels on one port with no drift between them. Sample A always goes first and its partner sample B follows. The bits of the two channels are never interleaved.

The block runs from one clock at twice the input bit rate. For a 10.4 MHz input bit clock, that clock is 20.8 MHz. A strobe marks the cycles in which an input bit is valid, and the output moves one bit on every clock cycle. Both sides use I2S-style framing: the most significant bit comes first, one bit slot after each word-select edge, and the least significant bit shares a slot with the next edge. The output word-select toggles once per 32-bit output pair, so the frame rate is the same as at the input. The input word-select level is ignored; only its transitions matter.

Top module: `dual_stream_interleaver`

## Requirements
- R1: While reset is high, and after it until the first pair is sent, `sd_out` and `ws_out` are 0.
- R2: Inputs are sampled only in cycles with `bit_en` = 1. A change of `ws_in` between two such samples marks that sample as the LSB of the current words. The 16 bits ending there, MSB first, form one sample per line.
- R3: The first `ws_in` transition seen after reset only arms the block. The word that ends at that transition is discarded, and capture starts with the word that ends at the next transition.
- R4: Each pair is sent as 32 consecutive output bits, one per clock. First come the 16 bits of line A, MSB first, then the 16 bits of line B captured at the same transition, MSB first.
- R5: The MSB of A appears on `sd_out` exactly two clocks after the `bit_en` cycle that carried the LSBs. Pairs follow each other with no gap.
- R6: `ws_out` toggles one clock after that `bit_en` cycle, which is one output bit before the MSB of A. It is low before the first toggle, and it toggles once per pair.
- R7: Inverting the `ws_in` level for a whole run gives the same output.
- R8: Changes on `ws_in`, `sd_a` and `sd_b` in cycles with `bit_en` = 0 have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the input bit rate |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Input bit valid strobe, every second cycle |
| ws_in | input | 1 | Shared input word-select |
| sd_a | input | 1 | Serial data, line A |
| sd_b | input | 1 | Serial data, line B |
| sd_out | output | 1 | Interleaved serial data out |
| ws_out | output | 1 | Output word-select, one toggle per pair |

## Verification
The stream test uses a table of sample pairs. Complementary pairs such as all-ones against all-zeros show that A goes first and that the halves are not swapped. Alternating and edge-bit patterns (0x8001, 0xAAAA) expose bit-order reversal and off-by-one bit slips. The first table entry must never appear on the output, which pins down the arming rule. The same table is run again with the word-select level inverted, and the bench drives inverted data and word-select on the strobe-low cycles, so any sampling outside `bit_en` changes the stream.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
  localparam int unsigned DSI_SAMPLE_W = 16;
  localparam int unsigned DSI_LANES    = 2;
endpackage

// File: rtl/dsi_lane_shift.sv
module dsi_lane_shift #(
  parameter int unsigned W = dsi_pkg::DSI_SAMPLE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_en,
  input  logic         sd,
  output logic [W-1:0] word_nxt
);
  logic [W-2:0] sr;

  always_ff @(posedge clk) begin
    if (rst)         sr <= '0;
    else if (bit_en) sr <= {sr[W-3:0], sd};
  end

  assign word_nxt = {sr, sd};

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(sr));
endmodule

// File: rtl/dsi_frame_ctl.sv
module dsi_frame_ctl (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic ws_in,
  output logic cap
);
  logic ws_q, seen, armed, ws_edge;

  assign ws_edge = bit_en && seen && (ws_in != ws_q);
  assign cap     = ws_edge && armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_q  <= 1'b0;
      seen  <= 1'b0;
      armed <= 1'b0;
    end else if (bit_en) begin
      ws_q <= ws_in;
      seen <= 1'b1;
      if (ws_edge) armed <= 1'b1;
    end
  end

  // R3
  arm_first_chk: assert property (@(posedge clk) disable iff (rst)
    cap |-> $past(seen));
endmodule

// File: rtl/dsi_pair_buf.sv
module dsi_pair_buf #(
  parameter int unsigned W = dsi_pkg::DSI_SAMPLE_W,
  localparam int unsigned PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic [W-1:0]  word_a,
  input  logic [W-1:0]  word_b,
  output logic [PW-1:0] pair,
  output logic          pair_new
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pair     <= '0;
      pair_new <= 1'b0;
    end else begin
      pair_new <= cap;
      if (cap) pair <= {word_a, word_b};
    end
  end

  // R2
  cap_word_chk: assert property (@(posedge clk) disable iff (rst)
    cap |=> (pair[PW-1:W] == $past(word_a)) && (pair[W-1:0] == $past(word_b)));
endmodule

// File: rtl/dsi_pair_ser.sv
module dsi_pair_ser #(
  parameter int unsigned W = dsi_pkg::DSI_SAMPLE_W,
  localparam int unsigned PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap,
  input  logic          load,
  input  logic [PW-1:0] pair,
  output logic          sd_out,
  output logic          ws_out
);
  logic [PW-1:0] osr;

  always_ff @(posedge clk) begin
    if (rst) begin
      osr    <= '0;
      ws_out <= 1'b0;
    end else begin
      if (load) osr <= pair;
      else      osr <= {osr[PW-2:0], 1'b0};
      if (cap)  ws_out <= ~ws_out;
    end
  end

  assign sd_out = osr[PW-1];

  // R4
  msb_first_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> sd_out == $past(pair[PW-1]));
  // R6
  ws_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ws_out) |-> $past(cap));
endmodule

// File: rtl/dual_stream_interleaver.sv
module dual_stream_interleaver #(
  parameter int unsigned SAMPLE_W = dsi_pkg::DSI_SAMPLE_W,
  localparam int unsigned LANES = dsi_pkg::DSI_LANES,
  localparam int unsigned PAIR_W = 2 * SAMPLE_W
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic ws_in,
  input  logic sd_a,
  input  logic sd_b,
  output logic sd_out,
  output logic ws_out
);
  logic [LANES-1:0]    sd_lane;
  logic [SAMPLE_W-1:0] lane_word [LANES];
  logic                cap, pair_new;
  logic [PAIR_W-1:0]   pair;

  assign sd_lane = {sd_b, sd_a};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dsi_lane_shift #(.W(SAMPLE_W)) u_lane (
      .clk(clk), .rst(rst), .bit_en(bit_en),
      .sd(sd_lane[g]), .word_nxt(lane_word[g])
    );
  end

  dsi_frame_ctl u_frame (
    .clk(clk), .rst(rst), .bit_en(bit_en), .ws_in(ws_in), .cap(cap)
  );

  dsi_pair_buf #(.W(SAMPLE_W)) u_buf (
    .clk(clk), .rst(rst), .cap(cap),
    .word_a(lane_word[0]), .word_b(lane_word[1]),
    .pair(pair), .pair_new(pair_new)
  );

  dsi_pair_ser #(.W(SAMPLE_W)) u_ser (
    .clk(clk), .rst(rst), .cap(cap), .load(pair_new), .pair(pair),
    .sd_out(sd_out), .ws_out(ws_out)
  );

  // R1
  idle_reset_chk: assert property (@(posedge clk)
    $past(rst) |-> !sd_out && !ws_out);
endmodule

// File: tb/sim_dual_stream_interleaver.sv
module sim_dual_stream_interleaver;
  localparam int CLK_P = 10;
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    32'hA5C3_3C5A, 32'hFFFF_0000, 32'h0000_FFFF,
    32'h8001_7FFE, 32'h1234_FEDC, 32'hAAAA_5555
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, ws_in = 1'b0, sd_a = 1'b0, sd_b = 1'b0;
  logic sd_out, ws_out;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  dual_stream_interleaver u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .ws_in(ws_in),
    .sd_a(sd_a), .sd_b(sd_b), .sd_out(sd_out), .ws_out(ws_out)
  );

  function automatic logic [31:0] word_at(int j);
    return (j >= 0 && j < NV) ? VEC[j] : 32'h0;
  endfunction

  task automatic check(string req, logic act, logic exp, int m);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %b expected %b", req, m, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; bit_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset sd", sd_out, 1'b0, -1);
    check("R1 reset ws", ws_out, 1'b0, -1);
    rst = 1'b0;
  endtask

  // One run of the vector table; inv flips the input word-select level (R7)
  task automatic run_stream(logic inv, string tag);
    int total;
    total = 2 * 16 * (NV + 2);
    for (int m = 0; m < total; m++) begin
      int n, mp, mq, j;
      logic [31:0] w;
      logic exp_sd, exp_ws, a_bit, b_bit, ws_bit;
      @(negedge clk);
      if (m > 0) begin
        mp = m - 2;
        if (mp < 64) exp_sd = 1'b0;   // R1, R3: first word dropped
        else begin
          w = word_at(mp / 32 - 1);
          exp_sd = w[31 - (mp % 32)];  // R4, R5: A then B, MSB first
        end
        mq = m - 1;
        exp_ws = (mq < 64) ? 1'b0 : 1'((mq / 32 - 1) & 1);  // R6
        check({"R4 R5 sd ", tag}, sd_out, exp_sd, m);
        check({"R6 ws ", tag}, ws_out, exp_ws, m);
      end
      n = m / 2;
      ws_bit = 1'((n / 16) & 1) ^ inv;
      a_bit = 1'b0; b_bit = 1'b0;
      if (n >= 1) begin
        j = (n - 1) / 16;
        w = word_at(j);
        a_bit = w[16 + 15 - ((n - 1) % 16)];
        b_bit = w[15 - ((n - 1) % 16)];
      end
      if (m % 2 == 0) begin
        bit_en = 1'b1; ws_in = ws_bit; sd_a = a_bit; sd_b = b_bit;
      end else begin
        // R8: junk on strobe-low cycles
        bit_en = 1'b0; ws_in = ~ws_bit; sd_a = ~a_bit; sd_b = ~b_bit;
      end
    end
    bit_en = 1'b0;
  endtask

  initial begin
    #(CLK_P * 20000);
    n_bad++;
    $display("FAIL watchdog: actual hung, expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    check("R1 idle sd", sd_out, 1'b0, 0);
    check("R1 idle ws", ws_out, 1'b0, 0);
    run_stream(1'b0, "normal");
    do_reset();
    run_stream(1'b1, "R7 inverted");
    // R1: reset in the middle of a stream
    do_reset();
    repeat (4) @(negedge clk);
    check("R1 after reset sd", sd_out, 1'b0, 0);
    check("R1 after reset ws", ws_out, 1'b0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule